// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block holds a five-bit condition code register with an extend flag, a negative flag, a zero flag, an overflow flag and a carry flag. It sits beside an ALU. After each operation the datapath presents four things: an operation-class code, the operand size, the ALU result, and the status bits that come with that result. These are the sign bits of the source and destination operands and the raw carry (or borrow) at the selected size. One write strobe then commits the new flag values. Each class has its own rule for each flag. A flag can be computed, forced to 0, forced to 1, or kept. The extend flag has a separate rule from the carry flag, so it carries over from one operation to the next.

The same port set can also load the register directly, or combine it with an immediate byte using AND, OR or XOR. In those cases the low five bits of the result bus carry the immediate. Flags that an operation leaves undefined keep their previous value, so the outcome is deterministic. The arithmetic itself, instruction decoding and any wider status word are handled elsewhere.

Top module: `ccr_flag_unit`

## Requirements
- R1: A synchronous active-low reset clears the register to 5'b00000. While `wr_i` is low the register holds its value whatever the other inputs carry.
- R2: Class code 0 (address-register arithmetic or move) leaves all five flags unchanged.
- R3: Class codes 1 (add), 2 (subtract, destination minus source) and 3 (negate) work as follows:
  - C takes `carry_i` and X takes the same value.
  - N is the result sign and Z shows a zero result.
  - V for add is 1 when both operand signs are equal and the result sign differs from them.
  - V for subtract is 1 when the operand signs differ and the result sign differs from the destination sign.
  - V for negate is the destination sign AND the result sign.
- R4: Class code 8 (logical AND/OR/XOR/NOT, move, test, sign-extend and multiply) keeps X, sets N and Z from the result, and forces V and C to 0.
- R5: Class code 9 (clear) keeps X and gives N=0, Z=1, V=0, C=0.
- R6: Class code 7 (compare) updates N, Z, V and C with the subtract rules of R3 and keeps X.
- R7: Class code 10 (divide) keeps X, sets N and Z from the result, takes V from `carry_i` (the divider's overflow indication), and forces C to 0.
- R8: Class code 11 (bit test, set, clear or change) gives Z the complement of `res_i[0]`, which holds the original value of the tested bit. X, N, V and C keep their values.
- R9: Class codes 4, 5 and 6 (add, subtract and negate with extend) follow the rules of their base class in R3, except for Z. Z becomes 0 on a nonzero result and otherwise keeps its value, so Z never goes from 0 to 1.
- R10: `size_i` selects the width used for N and Z:
  - 0 (byte): N is result bit 7 and Z looks at bits 7:0.
  - 1 (word): N is bit 15 and Z looks at bits 15:0.
  - 2 or 3 (long): N is bit 31 and Z looks at bits 31:0.
- R11: Class code 12 loads the register with `res_i[4:0]`. The register bit layout is X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R12: Class codes 13, 14 and 15 replace the register with its bitwise AND, OR or XOR (in that order) with `res_i[4:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_i | input | 1 | Commit strobe for the flag update |
| op_i | input | 4 | Operation-class code |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| res_i | input | DW | ALU result, or the immediate in bits 4:0 |
| src_msb_i | input | 1 | Sign bit of the source operand |
| dst_msb_i | input | 1 | Sign bit of the destination operand |
| carry_i | input | 1 | Raw carry/borrow at the selected size, or divide overflow |
| ccr_o | output | 5 | Flag register {X,N,Z,V,C} |

## Verification
The checker watches several rules on every committed cycle:
- the register holds while the strobe is low, and address-register classes never disturb it;
- X equals C after every arithmetic class;
- the fixed values that clear, logical and divide classes force into their flags;
- the bit-test class touches only Z;
- the extended classes never raise Z;
- a direct load is copied exactly.

Other behaviour depends on data, and only the bench's scenarios show it:
- the three overflow formulas;
- the width-dependent choice of the sign bit and of the zero span;
- the three immediate combinations applied to known prior flag values;
- recovery from a reset issued mid-run.

// File: rtl/ccr_pkg.sv
// Package: shared types for the condition code flag unit.
// Assumes the register layout {X,N,Z,V,C} with X in bit 4.
package ccr_pkg;

    localparam int NFLAGS = 5;
    localparam int FX = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FV = 1;
    localparam int FC = 0;

    typedef enum logic [3:0] {
        OPC_ADDR  = 4'd0,
        OPC_ADD   = 4'd1,
        OPC_SUB   = 4'd2,
        OPC_NEG   = 4'd3,
        OPC_ADDX  = 4'd4,
        OPC_SUBX  = 4'd5,
        OPC_NEGX  = 4'd6,
        OPC_CMP   = 4'd7,
        OPC_LOGIC = 4'd8,
        OPC_CLR   = 4'd9,
        OPC_DIV   = 4'd10,
        OPC_BIT   = 4'd11,
        OPC_LOAD  = 4'd12,
        OPC_ANDI  = 4'd13,
        OPC_ORI   = 4'd14,
        OPC_XORI  = 4'd15
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } op_size_e;

    // Per-flag action chosen by the class decoder.
    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_CALC = 2'd1,
        ACT_ZERO = 2'd2,
        ACT_ONE  = 2'd3
    } flag_act_e;

    typedef enum logic [1:0] {
        DIR_LOAD = 2'd0,
        DIR_AND  = 2'd1,
        DIR_OR   = 2'd2,
        DIR_XOR  = 2'd3
    } dir_mode_e;

endpackage

// File: rtl/ccr_size_view.sv
// Size view: picks the sign bit and zero test for byte, word or long.
// Assumes DW is a multiple of 4, byte = DW/4 and word = DW/2 bits.
module ccr_size_view #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] res_i,
    input  logic [1:0]    size_i,
    output logic          msb_o,
    output logic          zero_o
);
    localparam int BW = DW / 4;
    localparam int WW = DW / 2;

    logic z_byte, z_word, z_long;

    // Zero detection for each width.
    always_comb begin
        z_byte = ~|res_i[BW-1:0];
        z_word = ~|res_i[WW-1:0];
        z_long = ~|res_i;
    end

    // Select the sign bit and zero flag by size; code 3 acts as long.
    always_comb begin
        case (size_i)
            2'd0:    begin msb_o = res_i[BW-1]; zero_o = z_byte; end
            2'd1:    begin msb_o = res_i[WW-1]; zero_o = z_word; end
            default: begin msb_o = res_i[DW-1]; zero_o = z_long; end
        endcase
    end
endmodule

// File: rtl/ccr_class_decode.sv
// Class decoder: maps an operation class to one action per flag and
// flags the direct-write classes. Purely combinational.
module ccr_class_decode
    import ccr_pkg::*;
(
    input  logic [3:0]               op_i,
    output flag_act_e [NFLAGS-1:0]   act_o,
    output logic                     direct_o,
    output dir_mode_e                dir_mode_o
);
    op_class_e op;
    assign op = op_class_e'(op_i);

    // Per-class action table, one entry per flag.
    always_comb begin
        act_o      = {NFLAGS{ACT_KEEP}};
        direct_o   = 1'b0;
        dir_mode_o = DIR_LOAD;
        case (op)
            OPC_ADD, OPC_SUB, OPC_NEG,
            OPC_ADDX, OPC_SUBX, OPC_NEGX: begin
                act_o[FX] = ACT_CALC;
                act_o[FN] = ACT_CALC;
                act_o[FZ] = ACT_CALC;
                act_o[FV] = ACT_CALC;
                act_o[FC] = ACT_CALC;
            end
            OPC_CMP: begin
                act_o[FN] = ACT_CALC;
                act_o[FZ] = ACT_CALC;
                act_o[FV] = ACT_CALC;
                act_o[FC] = ACT_CALC;
            end
            OPC_LOGIC: begin
                act_o[FN] = ACT_CALC;
                act_o[FZ] = ACT_CALC;
                act_o[FV] = ACT_ZERO;
                act_o[FC] = ACT_ZERO;
            end
            OPC_CLR: begin
                act_o[FN] = ACT_ZERO;
                act_o[FZ] = ACT_ONE;
                act_o[FV] = ACT_ZERO;
                act_o[FC] = ACT_ZERO;
            end
            OPC_DIV: begin
                act_o[FN] = ACT_CALC;
                act_o[FZ] = ACT_CALC;
                act_o[FV] = ACT_CALC;
                act_o[FC] = ACT_ZERO;
            end
            OPC_BIT: begin
                act_o[FZ] = ACT_CALC;
            end
            OPC_LOAD: begin
                direct_o   = 1'b1;
                dir_mode_o = DIR_LOAD;
            end
            OPC_ANDI: begin
                direct_o   = 1'b1;
                dir_mode_o = DIR_AND;
            end
            OPC_ORI: begin
                direct_o   = 1'b1;
                dir_mode_o = DIR_OR;
            end
            OPC_XORI: begin
                direct_o   = 1'b1;
                dir_mode_o = DIR_XOR;
            end
            default: begin
                act_o = {NFLAGS{ACT_KEEP}};
            end
        endcase
    end
endmodule

// File: rtl/ccr_flag_calc.sv
// Flag calculator: computes candidate flag values and the direct-write
// value. Assumes carry_i is already taken at the selected operand size.
module ccr_flag_calc
    import ccr_pkg::*;
(
    input  logic [3:0]        op_i,
    input  logic              msb_i,
    input  logic              zero_i,
    input  logic              bit0_i,
    input  logic              src_msb_i,
    input  logic              dst_msb_i,
    input  logic              carry_i,
    input  logic [NFLAGS-1:0] imm_i,
    input  logic [NFLAGS-1:0] ccr_q_i,
    input  dir_mode_e         dir_mode_i,
    output logic [NFLAGS-1:0] calc_o,
    output logic [NFLAGS-1:0] direct_val_o
);
    op_class_e op;
    logic      v_add, v_sub, v_neg;

    assign op = op_class_e'(op_i);

    // Overflow candidates for the three arithmetic forms.
    always_comb begin
        v_add = (src_msb_i == dst_msb_i) && (msb_i != src_msb_i);
        v_sub = (src_msb_i != dst_msb_i) && (msb_i != dst_msb_i);
        v_neg = dst_msb_i & msb_i;
    end

    // Candidate values used when a flag's action is CALC.
    always_comb begin
        calc_o     = '0;
        calc_o[FX] = carry_i;
        calc_o[FC] = carry_i;
        calc_o[FN] = msb_i;
        case (op)
            OPC_ADDX, OPC_SUBX, OPC_NEGX: calc_o[FZ] = ccr_q_i[FZ] & zero_i;
            OPC_BIT:                      calc_o[FZ] = ~bit0_i;
            default:                      calc_o[FZ] = zero_i;
        endcase
        case (op)
            OPC_ADD, OPC_ADDX:           calc_o[FV] = v_add;
            OPC_SUB, OPC_SUBX, OPC_CMP:  calc_o[FV] = v_sub;
            OPC_NEG, OPC_NEGX:           calc_o[FV] = v_neg;
            OPC_DIV:                     calc_o[FV] = carry_i;
            default:                     calc_o[FV] = 1'b0;
        endcase
    end

    // Whole-register value for load and immediate-combine classes.
    always_comb begin
        case (dir_mode_i)
            DIR_AND: direct_val_o = ccr_q_i & imm_i;
            DIR_OR:  direct_val_o = ccr_q_i | imm_i;
            DIR_XOR: direct_val_o = ccr_q_i ^ imm_i;
            default: direct_val_o = imm_i;
        endcase
    end
endmodule

// File: rtl/ccr_flag_unit.sv
// Top: condition code register with per-class flag update rules.
// Assumes one update per strobe; the upper result bits carry no meaning
// for the direct-write classes.
module ccr_flag_unit
    import ccr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [3:0]    op_i,
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] res_i,
    input  logic          src_msb_i,
    input  logic          dst_msb_i,
    input  logic          carry_i,
    output logic [4:0]    ccr_o
);
    logic [NFLAGS-1:0]      ccr_q, ccr_d, per_flag, calc, direct_val;
    flag_act_e [NFLAGS-1:0] act;
    logic                   direct;
    dir_mode_e              dir_mode;
    logic                   msb, zero;

    ccr_size_view #(.DW(DW)) size_i0 (
        .res_i  (res_i),
        .size_i (size_i),
        .msb_o  (msb),
        .zero_o (zero)
    );

    ccr_class_decode dec_i (
        .op_i       (op_i),
        .act_o      (act),
        .direct_o   (direct),
        .dir_mode_o (dir_mode)
    );

    ccr_flag_calc calc_i (
        .op_i         (op_i),
        .msb_i        (msb),
        .zero_i       (zero),
        .bit0_i       (res_i[0]),
        .src_msb_i    (src_msb_i),
        .dst_msb_i    (dst_msb_i),
        .carry_i      (carry_i),
        .imm_i        (res_i[NFLAGS-1:0]),
        .ccr_q_i      (ccr_q),
        .dir_mode_i   (dir_mode),
        .calc_o       (calc),
        .direct_val_o (direct_val)
    );

    // One next-value selector per flag.
    for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
        // Apply the decoded action to flag f.
        always_comb begin
            case (act[f])
                ACT_CALC: per_flag[f] = calc[f];
                ACT_ZERO: per_flag[f] = 1'b0;
                ACT_ONE:  per_flag[f] = 1'b1;
                default:  per_flag[f] = ccr_q[f];
            endcase
        end
    end

    // Direct-write classes override the per-flag path.
    always_comb begin
        ccr_d = direct ? direct_val : per_flag;
    end

    // Flag register: reset to zero, update only on the strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ccr_q <= '0;
        end else if (wr_i) begin
            ccr_q <= ccr_d;
        end
    end

    assign ccr_o = ccr_q;
endmodule

// File: rtl/ccr_flag_unit_chk.sv
// Checker: cycle properties of the flag unit, observed at its ports.
module ccr_flag_unit_chk
    import ccr_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_i,
    input logic [3:0] op_i,
    input logic [4:0] res_lo_i,
    input logic [4:0] ccr_o
);
    logic arith, extd;
    assign arith = (op_i >= 4'd1) && (op_i <= 4'd6);
    assign extd  = (op_i >= 4'd4) && (op_i <= 4'd6);

    // R1: no strobe, no change
    a_r1_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(ccr_o));

    // R2: address-register class leaves flags alone
    a_r2_addr_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OPC_ADDR) |=> $stable(ccr_o));

    // R3: extend follows carry for arithmetic classes
    a_r3_x_equals_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && arith) |=> (ccr_o[FX] == ccr_o[FC]));

    // R4: logical class clears V and C, keeps X
    a_r4_logic_vc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OPC_LOGIC) |=> (ccr_o[1:0] == 2'b00) && $stable(ccr_o[FX]));

    // R5: clear class fixed pattern
    a_r5_clear_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OPC_CLR) |=> (ccr_o[3:0] == 4'b0100) && $stable(ccr_o[FX]));

    // R7: divide clears C, keeps X
    a_r7_div_c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OPC_DIV) |=> !ccr_o[FC] && $stable(ccr_o[FX]));

    // R8: bit class touches only Z
    a_r8_bit_only_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OPC_BIT) |=> (ccr_o[FZ] == !$past(res_lo_i[0]))
            && $stable(ccr_o[4:3]) && $stable(ccr_o[1:0]));

    // R9: extended classes never raise Z
    a_r9_z_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && extd) |=> !$rose(ccr_o[FZ]));

    // R11: direct load copies the immediate
    a_r11_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OPC_LOAD) |=> (ccr_o == $past(res_lo_i)));
endmodule

bind ccr_flag_unit ccr_flag_unit_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .op_i     (op_i),
    .res_lo_i (res_i[4:0]),
    .ccr_o    (ccr_o)
);

// File: tb/ccr_flag_unit_tb.sv
// Bench: table-driven walk of flag cases, then directed reset/strobe tests.
module ccr_flag_unit_tb_top;
    localparam int DW = 32;
    localparam int NV = 23;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wr_i = 1'b0;
    logic [3:0]    op_i = '0;
    logic [1:0]    size_i = '0;
    logic [DW-1:0] res_i = '0;
    logic          src_msb_i = 1'b0, dst_msb_i = 1'b0, carry_i = 1'b0;
    logic [4:0]    ccr_o;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    ccr_flag_unit #(.DW(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .op_i(op_i), .size_i(size_i),
        .res_i(res_i), .src_msb_i(src_msb_i), .dst_msb_i(dst_msb_i),
        .carry_i(carry_i), .ccr_o(ccr_o)
    );

    // Entry: {pre[4:0], op[3:0], size[1:0], res[31:0], src, dst, carry, exp[4:0]}
    localparam logic [50:0] VEC [NV] = '{
        {5'h00, 4'd1,  2'd2, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 5'h15}, // R3 add zero carry
        {5'h00, 4'd1,  2'd0, 32'h0000_0080, 1'b0, 1'b0, 1'b0, 5'h0A}, // R3 R10 add overflow byte
        {5'h1F, 4'd2,  2'd1, 32'h0001_0000, 1'b1, 1'b0, 1'b1, 5'h15}, // R3 R10 sub word zero
        {5'h00, 4'd3,  2'd2, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 5'h1B}, // R3 neg overflow
        {5'h1F, 4'd8,  2'd0, 32'h0000_0100, 1'b0, 1'b0, 1'b1, 5'h14}, // R4 R10 logic byte zero
        {5'h00, 4'd8,  2'd2, 32'hF000_0000, 1'b1, 1'b1, 1'b1, 5'h08}, // R4 logic negative
        {5'h1B, 4'd9,  2'd2, 32'h1234_5678, 1'b1, 1'b0, 1'b1, 5'h14}, // R5 clear
        {5'h00, 4'd7,  2'd2, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 5'h04}, // R6 cmp equal
        {5'h10, 4'd7,  2'd1, 32'h0000_8000, 1'b0, 1'b1, 1'b0, 5'h18}, // R6 cmp keeps X
        {5'h1F, 4'd10, 2'd1, 32'h0000_0005, 1'b0, 1'b0, 1'b1, 5'h12}, // R7 div overflow
        {5'h0F, 4'd11, 2'd2, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 5'h0B}, // R8 bit was one
        {5'h10, 4'd11, 2'd2, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 5'h14}, // R8 bit was zero
        {5'h04, 4'd4,  2'd2, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 5'h04}, // R9 addx keeps Z
        {5'h00, 4'd4,  2'd2, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 5'h00}, // R9 addx never sets Z
        {5'h04, 4'd5,  2'd0, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 5'h11}, // R9 subx clears Z
        {5'h04, 4'd6,  2'd1, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0, 5'h04}, // R9 R10 negx word zero
        {5'h1F, 4'd0,  2'd2, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 5'h1F}, // R2 address class
        {5'h0A, 4'd12, 2'd2, 32'hFFFF_FF15, 1'b0, 1'b0, 1'b0, 5'h15}, // R11 load
        {5'h1F, 4'd13, 2'd2, 32'h0000_000C, 1'b0, 1'b0, 1'b0, 5'h0C}, // R12 and imm
        {5'h03, 4'd14, 2'd2, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 5'h13}, // R12 or imm
        {5'h15, 4'd15, 2'd2, 32'h0000_001F, 1'b0, 1'b0, 1'b0, 5'h0A}, // R12 xor imm
        {5'h00, 4'd8,  2'd3, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 5'h08}, // R10 size 3 is long
        {5'h00, 4'd8,  2'd1, 32'h0000_8000, 1'b0, 1'b0, 1'b0, 5'h08}  // R10 word sign bit
    };

    task automatic check(input string req, input logic [4:0] exp);
        n_chk++;
        if (ccr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: ccr actual %b expected %b", req, ccr_o, exp);
        end
    endtask

    // Drive one strobed update at a falling edge; result visible next falling edge.
    task automatic apply(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] res,
                         input logic s, input logic d, input logic c, input logic wr);
        @(negedge clk);
        op_i = op; size_i = sz; res_i = res;
        src_msb_i = s; dst_msb_i = d; carry_i = c; wr_i = wr;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset value", 5'h00);
        rst_ni = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(4'd12, 2'd2, {27'd0, VEC[i][50:46]}, 1'b0, 1'b0, 1'b0, 1'b1);
            apply(VEC[i][45:42], VEC[i][41:40], VEC[i][39:8],
                  VEC[i][7], VEC[i][6], VEC[i][5], 1'b1);
            check($sformatf("vector %0d (R2-R12)", i), VEC[i][4:0]);
        end

        // R1: strobe low ignores a clear request
        apply(4'd12, 2'd2, 32'h1F, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd9, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 strobe low holds", 5'h1F);

        // R9: chained extended adds keep Z only while every part is zero
        apply(4'd12, 2'd2, 32'h04, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd4, 2'd2, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd4, 2'd2, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 chain zero lost", 5'h00);

        // R1: reset in mid-run clears the register
        apply(4'd12, 2'd2, 32'h1B, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst_ni = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
        check("R1 mid-run reset", 5'h00);

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule